// File: doc/BRIEF.md
# Receive Buffer Descriptor Manager

This block moves received frame bytes into a ring of fixed-size memory buffers. Software prepares a list of two-word descriptors in memory and hands the list base to the block through a queue pointer input. When a frame starts, the block reads the current descriptor and checks that software has released it. It then packs the incoming bytes into little-endian words and writes them into the buffer. If the frame is longer than the buffer, the block closes that buffer and moves on to the next descriptor. Each descriptor it closes gets its status word and its ownership flag written back.

A frame may cover several buffers. Only the descriptor of the last buffer receives the full frame status: the frame length, the end flag and the frame status bits supplied with the end-of-frame byte. Earlier descriptors receive only the start flag and the start offset, and only the first descriptor of the frame has these set. A 2-bit configuration value moves the start of the first buffer of a frame forward by 0 to 3 bytes, so that buffer holds fewer bytes.

If the descriptor the block fetches is still owned by the block, the rest of the frame is discarded. The block then raises a one-cycle no-buffer pulse and keeps the same descriptor for the next frame.

Top module: `rxd_desc_mgr`

## Requirements
- R1: A descriptor is two words at the current descriptor address. Word 0 holds the word-aligned buffer address in bits 31:2, the wrap flag in bit 1 and the ownership flag in bit 0. Word 1, at descriptor address + 4, is the status word.
- R2: A descriptor whose ownership bit reads 1 is not used. The block accepts the remaining bytes of the frame with `s_ready` high and writes nothing to memory. It pulses `nobuf_pulse` for exactly one cycle and does not advance the descriptor address.
- R3: When the block closes a buffer, it writes status word 1 first and then word 0. Word 0 goes back with the same address and wrap flag and with bit 0 set to 1.
- R4: The next descriptor lies 8 bytes after the current one. If the current descriptor has its wrap bit set, the next descriptor is at the queue base instead.
- R5: A buffer holds 128 bytes. Frame bytes are stored in order, and each word is little-endian (lane 0 is byte enable bit 0, data bits 7:0). A frame of exactly 128 bytes with offset 0 fits in one buffer and fetches no further descriptor.
- R6: The first buffer of a frame starts at buffer address + `cfg_offset` (0..3) and holds 128 − `cfg_offset` bytes. Every later buffer of the frame starts at offset 0.
- R7: Data words are written with byte enables set only for the lanes that carry frame bytes. All other bytes in memory stay unchanged.
- R8: When a frame continues past a buffer, that buffer's status word is all zero except for bit 14 (start of frame) and bits 13:12 (offset). Both are set only when the buffer is the first one of the frame.
- R9: The final status word holds the frame length in bytes in bits 11:0 and the end-of-frame flag in bit 15. Bits 31:16 hold `s_status` as latched with the end-of-frame byte. Bit 14 and bits 13:12 are set as in R8.
- R10: A pulse on `qptr_load` sets both the queue base and the current descriptor address to `qptr` with bits 1:0 cleared.
- R11: A memory request keeps `m_addr`, `m_we`, `m_wdata` and `m_be` steady until `m_ack`. The block never accepts a stream byte while a request is pending.
- R12: `frame_done` pulses for one cycle after the word 0 write of a frame's last buffer is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qptr_load | input | 1 | Load the queue pointer |
| qptr | input | AW | Descriptor list base address |
| cfg_offset | input | 2 | Start offset of the first buffer of a frame |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_eof | input | 1 | Marks the last byte of a frame |
| s_status | input | STAT_W | Frame status bits, valid with the end-of-frame byte |
| s_ready | output | 1 | The block accepts the stream byte |
| m_req | output | 1 | Memory request |
| m_we | output | 1 | Request is a write |
| m_addr | output | AW | Byte address, word aligned |
| m_wdata | output | 32 | Write data |
| m_be | output | 4 | Byte enables for writes |
| m_ack | input | 1 | Request completed |
| m_rdata | input | 32 | Read data, valid with `m_ack` |
| nobuf_pulse | output | 1 | Fetched descriptor was still owned; frame dropped |
| frame_done | output | 1 | A frame has been fully stored |

## Verification
The hardest situation to reach is a long frame with a nonzero start offset. It shortens the first buffer, leaves the second buffer with an all-zero status and ends in a third buffer. Only that path checks the chaining, the intermediate status words and the partial lane enables at both ends together. The bench builds that ring by hand, sends a 300-byte frame with offset 1 and checks every byte position and all three descriptors. The exact-fit frame of 128 bytes is sent separately, to show that the final write lands in one buffer and that the next descriptor is left untouched.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_FILL,
      ST_WDATA,
      ST_WSTAT,
      ST_WOWN,
      ST_DROP
   } rxd_state_e;

   localparam int SOF_BIT  = 14;
   localparam int EOF_BIT  = 15;
   localparam int OFS_LSB  = 12;
   localparam int STAT_LSB = 16;
   localparam int DESC_STRIDE = 8;
endpackage

// File: rtl/rxd_desc_ptr.sv
module rxd_desc_ptr #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] qbase,
   input  logic          advance,
   input  logic          wrap,
   output logic [AW-1:0] cur
);
   logic [AW-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cur    <= '0;
      end else if (load) begin
         base_q <= qbase;
         cur    <= qbase;
      end else if (advance) begin
         cur <= wrap ? base_q : cur + AW'(rxd_pkg::DESC_STRIDE);
      end
   end
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer #(
   parameter int BUF_BYTES = 128,
   parameter int LEN_W     = 12
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic [1:0]                        start_ofs,
   input  logic                              frame_start,
   input  logic                              push,
   input  logic [7:0]                        data,
   input  logic                              flush,
   output logic [31:0]                       word,
   output logic [3:0]                        be,
   output logic [$clog2(BUF_BYTES):0]        bp,
   output logic [LEN_W-1:0]                  flen
);
   localparam int BP_W = $clog2(BUF_BYTES) + 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bp   <= '0;
         be   <= '0;
         word <= '0;
      end else if (start) begin
         bp <= BP_W'(start_ofs);
         be <= '0;
      end else if (push) begin
         for (int l = 0; l < 4; l++) begin
            if (bp[1:0] == 2'(l)) begin
               word[l*8 +: 8] <= data;
               be[l]          <= 1'b1;
            end
         end
         bp <= bp + BP_W'(1);
      end else if (flush) begin
         be <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           flen <= '0;
      else if (frame_start) flen <= '0;
      else if (push)        flen <= flen + LEN_W'(1);
   end
endmodule

// File: rtl/rxd_desc_mgr.sv
module rxd_desc_mgr #(
   parameter int AW        = 32,
   parameter int BUF_BYTES = 128,
   parameter int LEN_W     = 12,
   parameter int STAT_W    = 16,
   parameter bit OFS_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qptr_load,
   input  logic [AW-1:0]     qptr,
   input  logic [1:0]        cfg_offset,
   input  logic              s_valid,
   input  logic [7:0]        s_data,
   input  logic              s_eof,
   input  logic [STAT_W-1:0] s_status,
   output logic              s_ready,
   output logic              m_req,
   output logic              m_we,
   output logic [AW-1:0]     m_addr,
   output logic [31:0]       m_wdata,
   output logic [3:0]        m_be,
   input  logic              m_ack,
   input  logic [31:0]       m_rdata,
   output logic              nobuf_pulse,
   output logic              frame_done
);
   import rxd_pkg::*;

   localparam int BP_W = $clog2(BUF_BYTES) + 1;

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("AW must lie in 8..32");
   end
   if ((BUF_BYTES & (BUF_BYTES - 1)) != 0 || BUF_BYTES < 8) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two of at least 8");
   end
   if (LEN_W > 12 || LEN_W < BP_W) begin : g_bad_len
      $error("LEN_W must fit the status field and hold one buffer");
   end
   if (STAT_W > 16 || STAT_W < 1) begin : g_bad_stat
      $error("STAT_W must lie in 1..16");
   end

   rxd_state_e        st;
   logic              first_q, eof_q, wrap_q;
   logic [1:0]        ofs_q, ofs_in;
   logic [STAT_W-1:0] stat_q;
   logic [AW-1:2]     baddr_q;
   logic [AW-1:0]     cur_desc;
   logic [31:0]       pk_word;
   logic [3:0]        pk_be;
   logic [BP_W-1:0]   pk_bp, bp_m1;
   logic [LEN_W-1:0]  pk_flen;
   logic              push, start, frame_start, flush, advance;
   logic [31:0]       stat_w;
   logic [AW-1:0]     word_off;
   logic              unused_bits;

   if (OFS_EN) begin : g_ofs
      assign ofs_in = cfg_offset;
   end else begin : g_no_ofs
      assign ofs_in = 2'b00;
   end

   assign unused_bits = ^{qptr[1:0], bp_m1[1:0], m_rdata[31:AW] == '0 ? 1'b0 : 1'b1};

   assign s_ready     = (st == ST_FILL) || (st == ST_DROP);
   assign push        = (st == ST_FILL) && s_valid;
   assign frame_start = (st == ST_IDLE) && s_valid;
   assign start       = (st == ST_FETCH) && m_ack && !m_rdata[0];
   assign flush       = (st == ST_WDATA) && m_ack;
   assign advance     = (st == ST_WOWN) && m_ack;

   rxd_desc_ptr #(.AW(AW)) i_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (qptr_load),
      .qbase  ({qptr[AW-1:2], 2'b00}),
      .advance(advance),
      .wrap   (wrap_q),
      .cur    (cur_desc)
   );

   rxd_packer #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) i_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_ofs  (first_q ? ofs_q : 2'b00),
      .frame_start(frame_start),
      .push       (push),
      .data       (s_data),
      .flush      (flush),
      .word       (pk_word),
      .be         (pk_be),
      .bp         (pk_bp),
      .flen       (pk_flen)
   );

   assign bp_m1    = pk_bp - BP_W'(1);
   assign word_off = AW'({bp_m1[BP_W-1:2], 2'b00});

   always_comb begin
      stat_w = '0;
      stat_w[SOF_BIT]        = first_q;
      stat_w[OFS_LSB +: 2]   = first_q ? ofs_q : 2'b00;
      if (eof_q) begin
         stat_w[EOF_BIT]            = 1'b1;
         stat_w[LEN_W-1:0]          = pk_flen;
         stat_w[STAT_LSB +: STAT_W] = stat_q;
      end
   end

   always_comb begin
      m_req   = 1'b0;
      m_we    = 1'b0;
      m_addr  = cur_desc;
      m_wdata = '0;
      m_be    = 4'hF;
      case (st)
         ST_FETCH: m_req = 1'b1;
         ST_WDATA: begin
            m_req   = 1'b1;
            m_we    = 1'b1;
            m_addr  = {baddr_q, 2'b00} + word_off;
            m_wdata = pk_word;
            m_be    = pk_be;
         end
         ST_WSTAT: begin
            m_req   = 1'b1;
            m_we    = 1'b1;
            m_addr  = cur_desc + AW'(4);
            m_wdata = stat_w;
         end
         ST_WOWN: begin
            m_req   = 1'b1;
            m_we    = 1'b1;
            m_wdata = 32'({baddr_q, wrap_q, 1'b1});
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         first_q     <= 1'b0;
         eof_q       <= 1'b0;
         wrap_q      <= 1'b0;
         ofs_q       <= 2'b00;
         stat_q      <= '0;
         baddr_q     <= '0;
         nobuf_pulse <= 1'b0;
         frame_done  <= 1'b0;
      end else begin
         nobuf_pulse <= 1'b0;
         frame_done  <= 1'b0;
         case (st)
            ST_IDLE: if (s_valid) begin
               first_q <= 1'b1;
               eof_q   <= 1'b0;
               ofs_q   <= ofs_in;
               st      <= ST_FETCH;
            end
            ST_FETCH: if (m_ack) begin
               if (m_rdata[0]) begin
                  nobuf_pulse <= 1'b1;
                  st          <= ST_DROP;
               end else begin
                  baddr_q <= m_rdata[AW-1:2];
                  wrap_q  <= m_rdata[1];
                  st      <= ST_FILL;
               end
            end
            ST_FILL: if (s_valid) begin
               if (s_eof) begin
                  eof_q  <= 1'b1;
                  stat_q <= s_status;
               end
               if (s_eof || pk_bp[1:0] == 2'd3) st <= ST_WDATA;
            end
            ST_WDATA: if (m_ack) begin
               if (eof_q || pk_bp == BP_W'(BUF_BYTES)) st <= ST_WSTAT;
               else                                     st <= ST_FILL;
            end
            ST_WSTAT: if (m_ack) st <= ST_WOWN;
            ST_WOWN: if (m_ack) begin
               first_q <= 1'b0;
               if (eof_q) begin
                  frame_done <= 1'b1;
                  st         <= ST_IDLE;
               end else begin
                  st <= ST_FETCH;
               end
            end
            ST_DROP: if (s_valid && s_eof) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxd_desc_chk.sv
module rxd_desc_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          m_req,
   input logic          m_we,
   input logic          m_ack,
   input logic [AW-1:0] m_addr,
   input logic [31:0]   m_wdata,
   input logic [3:0]    m_be,
   input logic          s_ready,
   input logic          nobuf_pulse,
   input logic          frame_done
);
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_we)
                          && $stable(m_wdata) && $stable(m_be));

   p_no_byte_in_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> !m_req);

   p_nobuf_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      nobuf_pulse |=> !nobuf_pulse);

   p_nobuf_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      nobuf_pulse |-> !m_req);

   p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   p_write_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      m_req && m_we |-> m_be != 4'b0000);

   p_word_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      m_req |-> m_addr[1:0] == 2'b00);
endmodule

bind rxd_desc_mgr rxd_desc_chk #(.AW(AW)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .m_req      (m_req),
   .m_we       (m_we),
   .m_ack      (m_ack),
   .m_addr     (m_addr),
   .m_wdata    (m_wdata),
   .m_be       (m_be),
   .s_ready    (s_ready),
   .nobuf_pulse(nobuf_pulse),
   .frame_done (frame_done)
);

// File: tb/test_rxd_desc_mgr.sv
module test_rxd_desc_mgr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        qptr_load = 1'b0;
   logic [31:0] qptr = '0;
   logic [1:0]  cfg_offset = 2'b00;
   logic        s_valid = 1'b0;
   logic [7:0]  s_data = '0;
   logic        s_eof = 1'b0;
   logic [15:0] s_status = '0;
   logic        s_ready, m_req, m_we, nobuf_pulse, frame_done;
   logic [31:0] m_addr, m_wdata, m_rdata;
   logic [3:0]  m_be;
   logic        m_ack;

   logic [31:0] mem [0:1023];
   int checks = 0, fails = 0, done_cnt = 0, nobuf_cnt = 0;

   always #2 clk = ~clk;

   rxd_desc_mgr i_rxd_desc_mgr (
      .clk(clk), .rst_n(rst_n), .qptr_load(qptr_load), .qptr(qptr),
      .cfg_offset(cfg_offset), .s_valid(s_valid), .s_data(s_data),
      .s_eof(s_eof), .s_status(s_status), .s_ready(s_ready),
      .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_be(m_be), .m_ack(m_ack), .m_rdata(m_rdata),
      .nobuf_pulse(nobuf_pulse), .frame_done(frame_done)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ack   <= 1'b0;
         m_rdata <= '0;
      end else begin
         m_ack <= m_req && !m_ack;
         if (m_req && !m_ack) begin
            if (m_we) begin
               for (int l = 0; l < 4; l++)
                  if (m_be[l]) mem[m_addr[11:2]][l*8 +: 8] <= m_wdata[l*8 +: 8];
            end
            m_rdata <= mem[m_addr[11:2]];
         end
      end
      if (rst_n && frame_done)  done_cnt  <= done_cnt + 1;
      if (rst_n && nobuf_pulse) nobuf_cnt <= nobuf_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] bval(input int seed, input int i);
      return 8'((seed + i * 7) & 255);
   endfunction

   function automatic logic [7:0] mbyte(input int addr);
      return mem[addr >> 2][(addr & 3) * 8 +: 8];
   endfunction

   task automatic wmem(input int addr, input logic [31:0] v);
      mem[addr >> 2] = v;
   endtask

   task automatic load_q(input logic [31:0] a);
      @(negedge clk);
      qptr = a; qptr_load = 1'b1;
      @(negedge clk);
      qptr_load = 1'b0;
   endtask

   task automatic send(input int len, input int seed, input logic [15:0] st);
      int d0 = done_cnt, n0 = nobuf_cnt;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         s_valid = 1'b1; s_data = bval(seed, i);
         s_eof = (i == len - 1); s_status = st;
         while (!s_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      s_valid = 1'b0; s_eof = 1'b0;
      for (int w = 0; w < 3000 && done_cnt == d0 && nobuf_cnt == n0; w++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_bytes(input int addr, input int cnt, input int seed, input int first, input string req);
      int bad = 0; logic [7:0] a = '0, e = '0;
      for (int k = 0; k < cnt; k++) begin
         if (mbyte(addr + k) !== bval(seed, first + k)) begin
            if (bad == 0) begin a = mbyte(addr + k); e = bval(seed, first + k); end
            bad++;
         end
      end
      chk(bad == 0, req, 32'(a), 32'(e));
   endtask

   task automatic t_reset;
      chk(m_req == 1'b0 && s_ready == 1'b0, "R11 reset idle", {30'b0, m_req, s_ready}, 32'h0);
      chk(nobuf_pulse == 1'b0 && frame_done == 1'b0, "R12 reset pulses",
          {30'b0, nobuf_pulse, frame_done}, 32'h0);
   endtask

   task automatic t_single;
      wmem(32'h100, 32'h400); wmem(32'h104, 32'hDEADBEEF);
      wmem(32'h108, 32'h480); wmem(32'h10C, 32'hDEADBEEF);
      load_q(32'h100);
      cfg_offset = 2'd0;
      send(6, 16, 16'hA5A5);
      chk_bytes(32'h400, 6, 16, 0, "R5 single frame bytes");
      chk(mem[32'h104 >> 2] == 32'hA5A5C006, "R9 final status", mem[32'h104 >> 2], 32'hA5A5C006);
      chk(mem[32'h100 >> 2] == 32'h401, "R3 ownership set", mem[32'h100 >> 2], 32'h401);
      chk(done_cnt == 1, "R12 done pulse", 32'(done_cnt), 32'd1);
      send(9, 51, 16'h1234);
      chk_bytes(32'h480, 9, 51, 0, "R4 next descriptor buffer");
      chk(mem[32'h10C >> 2] == 32'h1234C009, "R1 second status", mem[32'h10C >> 2], 32'h1234C009);
      chk(mem[32'h108 >> 2] == 32'h481, "R1 second owned", mem[32'h108 >> 2], 32'h481);
   endtask

   task automatic t_offset;
      wmem(32'h180, 32'h500); wmem(32'h184, 32'hDEADBEEF);
      for (int k = 0; k < 4; k++) wmem(32'h500 + 4 * k, 32'hFFFFFFFF);
      load_q(32'h180);
      cfg_offset = 2'd3;
      send(5, 3, 16'h0F0F);
      cfg_offset = 2'd0;
      chk(mem[32'h500 >> 2] == {bval(3, 0), 24'hFFFFFF}, "R7 leading lanes kept",
          mem[32'h500 >> 2], {bval(3, 0), 24'hFFFFFF});
      chk(mem[32'h504 >> 2] == {bval(3, 4), bval(3, 3), bval(3, 2), bval(3, 1)}, "R6 offset word",
          mem[32'h504 >> 2], {bval(3, 4), bval(3, 3), bval(3, 2), bval(3, 1)});
      chk(mem[32'h508 >> 2] == 32'hFFFFFFFF, "R7 trailing word kept", mem[32'h508 >> 2], 32'hFFFFFFFF);
      chk(mem[32'h184 >> 2] == 32'h0F0FF005, "R10 status at new base", mem[32'h184 >> 2], 32'h0F0FF005);
   endtask

   task automatic t_span;
      wmem(32'h100, 32'h600); wmem(32'h104, 32'hDEADBEEF);
      wmem(32'h108, 32'h680); wmem(32'h10C, 32'hDEADBEEF);
      wmem(32'h110, 32'h700); wmem(32'h114, 32'hDEADBEEF);
      load_q(32'h100);
      cfg_offset = 2'd1;
      send(300, 90, 16'hBEEF);
      cfg_offset = 2'd0;
      chk_bytes(32'h601, 127, 90, 0, "R6 first buffer shortened");
      chk_bytes(32'h680, 128, 90, 127, "R5 middle buffer");
      chk_bytes(32'h700, 45, 90, 255, "R5 last buffer");
      chk(mem[32'h104 >> 2] == 32'h00005000, "R8 first intermediate status", mem[32'h104 >> 2], 32'h5000);
      chk(mem[32'h10C >> 2] == 32'h0, "R8 middle status zero", mem[32'h10C >> 2], 32'h0);
      chk(mem[32'h114 >> 2] == 32'hBEEF812C, "R9 chained final status", mem[32'h114 >> 2], 32'hBEEF812C);
      chk(mem[32'h108 >> 2] == 32'h681, "R3 middle owned", mem[32'h108 >> 2], 32'h681);
   endtask

   task automatic t_exact;
      wmem(32'h100, 32'h800); wmem(32'h104, 32'hDEADBEEF);
      wmem(32'h108, 32'h880); wmem(32'h10C, 32'hDEADBEEF);
      load_q(32'h100);
      send(128, 7, 16'h0001);
      chk_bytes(32'h800, 128, 7, 0, "R5 exact fit bytes");
      chk(mem[32'h104 >> 2] == 32'h0001C080, "R5 exact fit status", mem[32'h104 >> 2], 32'h0001C080);
      chk(mem[32'h108 >> 2] == 32'h880 && mem[32'h10C >> 2] == 32'hDEADBEEF, "R5 next descriptor untouched",
          mem[32'h108 >> 2], 32'h880);
   endtask

   task automatic t_wrap;
      wmem(32'h100, 32'h900); wmem(32'h104, 32'hDEADBEEF);
      wmem(32'h108, 32'h982); wmem(32'h10C, 32'hDEADBEEF);
      wmem(32'h110, 32'hA00); wmem(32'h114, 32'hDEADBEEF);
      load_q(32'h100);
      send(4, 1, 16'h1111);
      send(4, 2, 16'h2222);
      chk(mem[32'h108 >> 2] == 32'h983, "R3 wrap flag kept", mem[32'h108 >> 2], 32'h983);
      wmem(32'h100, 32'h900);
      send(4, 5, 16'h3333);
      chk_bytes(32'h900, 4, 5, 0, "R4 wrap back to base");
      chk(mem[32'h110 >> 2] == 32'hA00 && mem[32'h114 >> 2] == 32'hDEADBEEF, "R4 past wrap untouched",
          mem[32'h110 >> 2], 32'hA00);
   endtask

   task automatic t_nobuf;
      int d0, n0;
      wmem(32'h100, 32'hB01); wmem(32'h104, 32'hDEADBEEF);
      wmem(32'hB00, 32'h0);
      load_q(32'h100);
      d0 = done_cnt; n0 = nobuf_cnt;
      send(10, 9, 16'h7777);
      chk(nobuf_cnt == n0 + 1 && done_cnt == d0, "R2 owned descriptor dropped",
          32'(nobuf_cnt - n0), 32'd1);
      chk(mem[32'hB00 >> 2] == 32'h0 && mem[32'h104 >> 2] == 32'hDEADBEEF, "R2 nothing written",
          mem[32'h104 >> 2], 32'hDEADBEEF);
      wmem(32'h100, 32'hB00);
      send(3, 4, 16'h5555);
      chk_bytes(32'hB00, 3, 4, 0, "R2 pointer not advanced");
      chk(mem[32'h104 >> 2] == 32'h5555C003, "R2 retry status", mem[32'h104 >> 2], 32'h5555C003);
   endtask

   initial begin
      for (int k = 0; k < 1024; k++) mem[k] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_single;
      t_offset;
      t_span;
      t_exact;
      t_wrap;
      t_nobuf;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule